// File: doc/BRIEF.md
# Block Move and Search Sequencer

This block runs the repeating and single-step block operations of an 8-bit processor core. It is loaded with a source pointer, a destination pointer, a 16-bit count register, the accumulator and the current flags. It then makes the memory and port accesses that the selected operation needs and writes back the updated pointers, count and flags. There are four operations. Copy moves bytes from memory to memory. Search compares memory bytes against the accumulator. Port-in moves bytes from an I/O port into memory. Port-out moves bytes from memory to an I/O port.

Any operation can step its pointers upward or downward, and it runs either once or until its end condition. The memory bus and the I/O bus are separate. Each uses a plain request/acknowledge handshake: a request is held until it is acknowledged, and the acknowledge may arrive in the same cycle as the request or any number of cycles later. The core issues a command when the block is idle and reads the results in the cycle that `done_o` pulses.

Top module: `blk_seq`

## Requirements
- R1: Copy reads the memory byte at the source pointer and writes it unchanged to the destination pointer. In a repeating copy, each byte is read after the previous byte has been written, so overlapping regions behave as a sequential byte loop.
- R2: Each step of copy, search or port transfer moves the source pointer by +1, or by -1 when `cmd_dec_i`=1. Copy also moves the destination pointer the same way. Copy and search reduce the full 16-bit count by one, so a starting count of 0 wraps to 0xFFFF and stands for 65536 bytes. Pointers wrap modulo 2^16.
- R3: With `cmd_rep_i`=0 a copy moves exactly one byte. With `cmd_rep_i`=1 it keeps stepping until the count reaches zero.
- R4: After a copy step, flag bit 4 (half-carry) and bit 1 (subtract) are 0. Bit 2 (parity/overflow) is 1 exactly when the new count is nonzero. Bits 7, 6, 5, 3 and 0 keep their loaded values.
- R5: Search (`cmd_op_i`=1) reads the byte at the source pointer, makes no writes and leaves the destination pointer unchanged. From r = acc - byte it sets bit 7 = r[7], bit 6 = (r==0), bit 4 = (acc[3:0] < byte[3:0]) and bit 1 = 1. Bit 2 is 1 exactly when the new count is nonzero. Bits 5, 3 and 0 are unchanged.
- R6: A repeating search stops after the step in which a match occurs or the count reaches zero, whichever comes first. The source pointer is then one past the matching byte in the stepping direction. If the search ends without a match, bit 6 is 0.
- R7: Port-in (`cmd_op_i`=2) reads the port at the address equal to the full 16-bit count register and writes that byte to memory at the source pointer. Only the upper count byte is reduced by one per step; the lower byte and the destination pointer are unchanged. Bit 6 is set to (upper byte == 0) and bit 1 to 1, and every other flag bit is kept.
- R8: Port-out (`cmd_op_i`=3) reads memory at the source pointer and writes the byte to the port at the address equal to the full count register. Counting and flags follow R7. An upper count byte of 0 at the start stands for 256 transfers. Repeating port forms run until the upper byte reaches zero.
- R9: The memory and I/O requests are never active in the same cycle. An unacknowledged request stays asserted in the next cycle with the same address.
- R10: A command is taken only when `busy_o` is 0, and a command offered while the block is busy has no effect. `busy_o` is 1 from the cycle after acceptance until the operation ends. `done_o` is a single-cycle pulse in the first idle cycle, and the result outputs are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offer |
| cmd_op_i | input | 2 | 0 copy, 1 search, 2 port-in, 3 port-out |
| cmd_dec_i | input | 1 | 1 = step pointers downward |
| cmd_rep_i | input | 1 | 1 = repeat until end condition |
| src_i | input | 16 | Initial source pointer |
| dst_i | input | 16 | Initial destination pointer |
| cnt_i | input | 16 | Initial count; upper byte is the port counter |
| acc_i | input | 8 | Accumulator for search |
| flags_i | input | 8 | Initial flags |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| src_o | output | 16 | Current source pointer |
| dst_o | output | 16 | Current destination pointer |
| cnt_o | output | 16 | Current count |
| flags_o | output | 8 | Current flags |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| io_req_o | output | 1 | Port request |
| io_we_o | output | 1 | Port write enable |
| io_addr_o | output | 16 | Port address |
| io_wdata_o | output | 8 | Port write data |
| io_rdata_i | input | 8 | Port read data, valid with acknowledge |
| io_ack_i | input | 1 | Port acknowledge |

## Verification
The hardest cases to reach are the early-termination corners. One is a repeating search whose match lands in the same step where the count runs out. Another is a search that matches part way through a run, so it must stop with count and pointer left mid-range. A third is a port transfer whose upper count byte starts at zero and must therefore run 256 times. The stimulus reaches these by setting the accumulator to the value a reference model places at a chosen offset from the start pointer, and by sweeping every operation, direction and repeat setting with counts of one and three. Random acknowledge stalls on both buses hold requests open across cycles throughout the sweep.

// File: rtl/blk_pkg.sv
package blk_pkg;
  localparam int FLAG_W = 8;
  localparam int FL_C   = 0;
  localparam int FL_N   = 1;
  localparam int FL_PV  = 2;
  localparam int FL_H   = 4;
  localparam int FL_Z   = 6;
  localparam int FL_S   = 7;

  typedef enum logic [1:0] {
    OP_COPY = 2'd0,
    OP_SRCH = 2'd1,
    OP_IN   = 2'd2,
    OP_OUT  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_STEP  = 2'd3
  } st_e;

  typedef struct packed {
    op_e  op;
    logic dec;
    logic rep;
  } cmd_t;
endpackage

// File: rtl/blk_cmp.sv
module blk_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] data_i,
  output logic          neg_o,
  output logic          zero_o,
  output logic          hb_o
);
  localparam int HW = DW / 2;
  logic [DW-1:0] diff;

  assign diff   = acc_i - data_i;
  assign neg_o  = diff[DW-1];
  assign zero_o = (diff == '0);
  assign hb_o   = (acc_i[HW-1:0] < data_i[HW-1:0]);
endmodule

// File: rtl/blk_ctrl.sv
module blk_ctrl
  import blk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  cmd_t cmd_i,
  input  logic rd_ack_i,
  input  logic wr_ack_i,
  input  logic stop_i,
  output st_e  state_o,
  output cmd_t cmd_o,
  output logic load_o,
  output logic cap_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  st_e  state_q, state_d;
  cmd_t cmd_q;
  logic done_q;
  logic again;

  assign load_o = start_i && (state_q == ST_IDLE);
  assign cap_o  = (state_q == ST_READ) && rd_ack_i;
  assign step_o = (state_q == ST_STEP);
  assign again  = cmd_q.rep && !stop_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (load_o) state_d = ST_READ;
      ST_READ:  if (rd_ack_i) state_d = (cmd_q.op == OP_SRCH) ? ST_STEP : ST_WRITE;
      ST_WRITE: if (wr_ack_i) state_d = ST_STEP;
      ST_STEP:  state_d = again ? ST_READ : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= step_o && !again;
      if (load_o) cmd_q <= cmd_i;
    end
  end

  assign state_o = state_q;
  assign cmd_o   = cmd_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
endmodule

// File: rtl/blk_bus.sv
module blk_bus
  import blk_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  st_e           state_i,
  input  op_e           op_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] cnt_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] io_rdata_i,
  input  logic          io_ack_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          io_req_o,
  output logic          io_we_o,
  output logic [AW-1:0] io_addr_o,
  output logic [DW-1:0] io_wdata_o,
  output logic          rd_ack_o,
  output logic          wr_ack_o,
  output logic [DW-1:0] rdata_o
);
  logic rd_ph, wr_ph, rd_io, wr_io;

  assign rd_ph = (state_i == ST_READ);
  assign wr_ph = (state_i == ST_WRITE);
  assign rd_io = (op_i == OP_IN);
  assign wr_io = (op_i == OP_OUT);

  // read side: port for port-in, memory otherwise; write side: port for port-out
  assign mem_req_o   = (rd_ph && !rd_io) || (wr_ph && !wr_io);
  assign mem_we_o    = wr_ph;
  assign mem_addr_o  = (wr_ph && op_i == OP_COPY) ? dst_i : src_i;
  assign mem_wdata_o = data_i;

  assign io_req_o    = (rd_ph && rd_io) || (wr_ph && wr_io);
  assign io_we_o     = wr_ph;
  assign io_addr_o   = cnt_i;
  assign io_wdata_o  = data_i;

  assign rd_ack_o = rd_io ? io_ack_i : mem_ack_i;
  assign wr_ack_o = wr_io ? io_ack_i : mem_ack_i;
  assign rdata_o  = rd_io ? io_rdata_i : mem_rdata_i;
endmodule

// File: rtl/blk_dp.sv
module blk_dp
  import blk_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              cap_i,
  input  logic              step_i,
  input  cmd_t              cmd_i,
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [AW-1:0]     cnt_i,
  input  logic [DW-1:0]     acc_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [DW-1:0]     rdata_i,
  input  logic              cmp_neg_i,
  input  logic              cmp_zero_i,
  input  logic              cmp_hb_i,
  output logic [AW-1:0]     src_o,
  output logic [AW-1:0]     dst_o,
  output logic [AW-1:0]     cnt_o,
  output logic [DW-1:0]     acc_o,
  output logic [DW-1:0]     data_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              stop_o
);
  localparam int BLO = AW - DW;

  logic [AW-1:0]     src_q, dst_q, cnt_q;
  logic [DW-1:0]     acc_q, data_q;
  logic [FLAG_W-1:0] fl_q, fl_d;
  logic [AW-1:0]     src_d, dst_d, cnt_d, pair_d;
  logic [DW-1:0]     hi_d;
  logic              is_io, last;

  assign is_io  = (cmd_i.op == OP_IN) || (cmd_i.op == OP_OUT);
  assign src_d  = cmd_i.dec ? src_q - AW'(1) : src_q + AW'(1);
  assign dst_d  = cmd_i.dec ? dst_q - AW'(1) : dst_q + AW'(1);
  assign pair_d = cnt_q - AW'(1);
  assign hi_d   = cnt_q[AW-1:BLO] - DW'(1);
  assign cnt_d  = is_io ? {hi_d, cnt_q[BLO-1:0]} : pair_d;
  assign last   = is_io ? (hi_d == '0) : (pair_d == '0);
  assign stop_o = last || ((cmd_i.op == OP_SRCH) && cmp_zero_i);

  always_comb begin
    fl_d = fl_q;
    unique case (cmd_i.op)
      OP_COPY: begin
        fl_d[FL_H]  = 1'b0;
        fl_d[FL_N]  = 1'b0;
        fl_d[FL_PV] = !last;
      end
      OP_SRCH: begin
        fl_d[FL_S]  = cmp_neg_i;
        fl_d[FL_Z]  = cmp_zero_i;
        fl_d[FL_H]  = cmp_hb_i;
        fl_d[FL_N]  = 1'b1;
        fl_d[FL_PV] = !last;
      end
      default: begin
        fl_d[FL_Z]  = last;
        fl_d[FL_N]  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
      data_q <= '0;
      fl_q   <= '0;
    end else if (load_i) begin
      src_q <= src_i;
      dst_q <= dst_i;
      cnt_q <= cnt_i;
      acc_q <= acc_i;
      fl_q  <= flags_i;
    end else begin
      if (cap_i) data_q <= rdata_i;
      if (step_i) begin
        src_q <= src_d;
        if (cmd_i.op == OP_COPY) dst_q <= dst_d;
        cnt_q <= cnt_d;
        fl_q  <= fl_d;
      end
    end
  end

  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign cnt_o   = cnt_q;
  assign acc_o   = acc_q;
  assign data_o  = data_q;
  assign flags_o = fl_q;
endmodule

// File: rtl/blk_seq.sv
module blk_seq
  import blk_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic              cmd_dec_i,
  input  logic              cmd_rep_i,
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [AW-1:0]     cnt_i,
  input  logic [DW-1:0]     acc_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [AW-1:0]     src_o,
  output logic [AW-1:0]     dst_o,
  output logic [AW-1:0]     cnt_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              io_req_o,
  output logic              io_we_o,
  output logic [AW-1:0]     io_addr_o,
  output logic [DW-1:0]     io_wdata_o,
  input  logic [DW-1:0]     io_rdata_i,
  input  logic              io_ack_i
);
  cmd_t          cmd_in, cmd_q;
  st_e           state;
  logic          load, cap, step, stop, rd_ack, wr_ack;
  logic          c_neg, c_zero, c_hb;
  logic [DW-1:0] acc_q, data_q, rdata;

  assign cmd_in.op  = op_e'(cmd_op_i);
  assign cmd_in.dec = cmd_dec_i;
  assign cmd_in.rep = cmd_rep_i;

  blk_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (cmd_valid_i),
    .cmd_i    (cmd_in),
    .rd_ack_i (rd_ack),
    .wr_ack_i (wr_ack),
    .stop_i   (stop),
    .state_o  (state),
    .cmd_o    (cmd_q),
    .load_o   (load),
    .cap_o    (cap),
    .step_o   (step),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  blk_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .cap_i      (cap),
    .step_i     (step),
    .cmd_i      (cmd_q),
    .src_i      (src_i),
    .dst_i      (dst_i),
    .cnt_i      (cnt_i),
    .acc_i      (acc_i),
    .flags_i    (flags_i),
    .rdata_i    (rdata),
    .cmp_neg_i  (c_neg),
    .cmp_zero_i (c_zero),
    .cmp_hb_i   (c_hb),
    .src_o      (src_o),
    .dst_o      (dst_o),
    .cnt_o      (cnt_o),
    .acc_o      (acc_q),
    .data_o     (data_q),
    .flags_o    (flags_o),
    .stop_o     (stop)
  );

  blk_cmp #(.DW(DW)) u_cmp (
    .acc_i  (acc_q),
    .data_i (data_q),
    .neg_o  (c_neg),
    .zero_o (c_zero),
    .hb_o   (c_hb)
  );

  blk_bus #(.AW(AW), .DW(DW)) u_bus (
    .state_i     (state),
    .op_i        (cmd_q.op),
    .src_i       (src_o),
    .dst_i       (dst_o),
    .cnt_i       (cnt_o),
    .data_i      (data_q),
    .mem_rdata_i (mem_rdata_i),
    .mem_ack_i   (mem_ack_i),
    .io_rdata_i  (io_rdata_i),
    .io_ack_i    (io_ack_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .io_req_o    (io_req_o),
    .io_we_o     (io_we_o),
    .io_addr_o   (io_addr_o),
    .io_wdata_o  (io_wdata_o),
    .rd_ack_o    (rd_ack),
    .wr_ack_o    (wr_ack),
    .rdata_o     (rdata)
  );
endmodule

// File: rtl/blk_seq_chk.sv
module blk_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [1:0]    cmd_op_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [AW-1:0] cnt_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ack_i,
  input logic          io_req_o,
  input logic [AW-1:0] io_addr_o,
  input logic          io_ack_i
);
  localparam logic [AW-1:0] HI_ONE = AW'(1) << (AW - DW);
  logic [1:0] kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kind_q <= 2'd0;
    else if (!busy_o && cmd_valid_i) kind_q <= cmd_op_i;
  end

  assert_excl_bus_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && io_req_o));

  assert_mem_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_io_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_req_o && !io_ack_i |=> io_req_o && $stable(io_addr_o));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !io_req_o);

  assert_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && cmd_valid_i |=> busy_o);

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) && (cnt_o != $past(cnt_o)) |->
      (cnt_o == $past(cnt_o) - AW'(1)) || (cnt_o == $past(cnt_o) - HI_ONE));

  assert_search_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (kind_q == 2'd1) |-> !(mem_req_o && mem_we_o) && !io_req_o);
endmodule

bind blk_seq blk_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .cnt_o       (cnt_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i),
  .io_req_o    (io_req_o),
  .io_addr_o   (io_addr_o),
  .io_ack_i    (io_ack_i)
);

// File: tb/tb_blk_seq.sv
module tb_blk_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = 2'd0;
  logic        cmd_dec_i = 1'b0;
  logic        cmd_rep_i = 1'b0;
  logic [15:0] src_i = '0, dst_i = '0, cnt_i = '0;
  logic [7:0]  acc_i = '0, flags_i = '0;
  logic        busy_o, done_o;
  logic [15:0] src_o, dst_o, cnt_o;
  logic [7:0]  flags_o;
  logic        mem_req_o, mem_we_o, mem_ack_i;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;
  logic        io_req_o, io_we_o, io_ack_i;
  logic [15:0] io_addr_o;
  logic [7:0]  io_wdata_o, io_rdata_i;

  int vectors = 0;
  int fails   = 0;

  always #5 clk_i = ~clk_i;

  blk_seq dut (.*);

  function automatic logic [7:0] fill_fn(input logic [7:0] i, input logic [7:0] sd);
    return (i * 8'd13) ^ sd;
  endfunction

  function automatic logic [7:0] port_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // memory and port models
  logic [7:0]  mem [256];
  logic [7:0]  emem [256];
  logic        fill_req = 1'b0;
  logic [7:0]  fill_seed = 8'h00;
  logic [15:0] io_cnt = '0, io_sum = '0;
  logic [4:0]  lfsr;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lfsr <= 5'h1F;
    else         lfsr <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};

  assign mem_ack_i   = mem_req_o & lfsr[0];
  assign io_ack_i    = io_req_o & lfsr[3];
  assign mem_rdata_i = mem[mem_addr_o[7:0]];
  assign io_rdata_i  = port_fn(io_addr_o);

  always @(posedge clk_i) begin
    if (fill_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= fill_fn(8'(i), fill_seed);
      io_cnt <= '0;
      io_sum <= '0;
    end else begin
      if (mem_req_o && mem_we_o && mem_ack_i) mem[mem_addr_o[7:0]] <= mem_wdata_o;
      if (io_req_o && io_we_o && io_ack_i) begin
        io_cnt <= io_cnt + 16'd1;
        io_sum <= io_sum + io_addr_o + {8'h00, io_wdata_o};
      end
    end
  end

  // bus protocol monitor (R9)
  int          excl_bad = 0, hold_bad = 0;
  logic        p_mreq = 1'b0, p_ireq = 1'b0;
  logic [15:0] p_maddr = '0, p_iaddr = '0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (mem_req_o && io_req_o) excl_bad++;
      if (p_mreq && (!mem_req_o || mem_addr_o != p_maddr)) hold_bad++;
      if (p_ireq && (!io_req_o || io_addr_o != p_iaddr)) hold_bad++;
      p_mreq  = mem_req_o && !mem_ack_i;
      p_ireq  = io_req_o && !io_ack_i;
      p_maddr = mem_addr_o;
      p_iaddr = io_addr_o;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic ref_model(input logic [1:0] op, input logic dec, input logic rep,
                           input logic [15:0] s0, input logic [15:0] d0, input logic [15:0] c0,
                           input logic [7:0] a, input logic [7:0] f0,
                           output logic [15:0] s, output logic [15:0] d, output logic [15:0] c,
                           output logic [7:0] f, output logic [15:0] ecnt, output logic [15:0] esum);
    logic [7:0] b, r;
    bit fin;
    s = s0; d = d0; c = c0; f = f0; ecnt = '0; esum = '0; fin = 0;
    while (!fin) begin
      case (op)
        2'd0: begin
          b = emem[s[7:0]];
          emem[d[7:0]] = b;
          s = dec ? s - 16'd1 : s + 16'd1;
          d = dec ? d - 16'd1 : d + 16'd1;
          c = c - 16'd1;
          f[4] = 1'b0; f[1] = 1'b0; f[2] = (c != 0);
          fin = !rep || (c == 0);
        end
        2'd1: begin
          b = emem[s[7:0]];
          r = a - b;
          s = dec ? s - 16'd1 : s + 16'd1;
          c = c - 16'd1;
          f[7] = r[7]; f[6] = (r == 0); f[4] = (a[3:0] < b[3:0]); f[1] = 1'b1; f[2] = (c != 0);
          fin = !rep || (c == 0) || (r == 0);
        end
        2'd2: begin
          emem[s[7:0]] = port_fn(c);
          s = dec ? s - 16'd1 : s + 16'd1;
          c[15:8] = c[15:8] - 8'd1;
          f[6] = (c[15:8] == 0); f[1] = 1'b1;
          fin = !rep || (c[15:8] == 0);
        end
        default: begin
          b = emem[s[7:0]];
          ecnt = ecnt + 16'd1;
          esum = esum + c + {8'h00, b};
          s = dec ? s - 16'd1 : s + 16'd1;
          c[15:8] = c[15:8] - 8'd1;
          f[6] = (c[15:8] == 0); f[1] = 1'b1;
          fin = !rep || (c[15:8] == 0);
        end
      endcase
    end
  endtask

  task automatic run(input logic [1:0] op, input logic dec, input logic rep,
                     input logic [15:0] s0, input logic [15:0] d0, input logic [15:0] c0,
                     input logic [7:0] a, input logic [7:0] f0, input logic [7:0] sd);
    logic [15:0] es, ed, ec, ecnt, esum;
    logic [7:0]  ef;
    string       rt, ft, mt;
    int          n, bad;
    @(negedge clk_i);
    fill_seed = sd;
    fill_req  = 1'b1;
    @(negedge clk_i);
    fill_req = 1'b0;
    for (int i = 0; i < 256; i++) emem[i] = fill_fn(8'(i), sd);
    ref_model(op, dec, rep, s0, d0, c0, a, f0, es, ed, ec, ef, ecnt, esum);
    rt = (op == 2'd0) ? (rep ? "R3" : "R2") : (op == 2'd1) ? (rep ? "R6" : "R2") : (op == 2'd2) ? "R7" : "R8";
    ft = (op == 2'd0) ? "R4" : (op == 2'd1) ? (rep ? "R6" : "R5") : (op == 2'd2) ? "R7" : "R8";
    mt = (op == 2'd0) ? "R1" : (op == 2'd1) ? "R5" : "R7";
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_dec_i = dec; cmd_rep_i = rep;
    src_i = s0; dst_i = d0; cnt_i = c0; acc_i = a; flags_i = f0;
    @(negedge clk_i);
    // offered while busy: must be ignored
    cmd_op_i = ~op; cmd_dec_i = ~dec; cmd_rep_i = 1'b1;
    src_i = 16'hDEAD; dst_i = 16'hBEEF; cnt_i = 16'h0000; acc_i = ~a; flags_i = ~f0;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk_i);
      n++;
    end
    chk(done_o, "R10 done", {31'd0, done_o}, 32'd1);
    if (!done_o) return;
    chk(!busy_o, "R10 idle at done", {31'd0, busy_o}, 32'd0);
    chk(src_o == es, rt, {16'd0, src_o}, {16'd0, es});
    chk(dst_o == ed, rt, {16'd0, dst_o}, {16'd0, ed});
    chk(cnt_o == ec, rt, {16'd0, cnt_o}, {16'd0, ec});
    chk(flags_o == ef, ft, {24'd0, flags_o}, {24'd0, ef});
    bad = -1;
    for (int i = 0; i < 256; i++) if (bad < 0 && mem[i] !== emem[i]) bad = i;
    if (bad < 0) chk(1'b1, mt, 32'd0, 32'd0);
    else         chk(1'b0, mt, {24'd0, mem[bad]}, {24'd0, emem[bad]});
    chk(io_cnt == ecnt && io_sum == esum, "R8 port writes", {io_cnt, io_sum}, {ecnt, esum});
    @(negedge clk_i);
    chk(!done_o, "R10 done pulse", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL R10 watchdog act=%0d exp=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [15:0] s, c;
    logic [7:0]  a, sd;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o, "R10 reset idle", {30'd0, busy_o, done_o}, 32'd0);
    chk(!mem_req_o && !io_req_o, "R9 reset quiet", {30'd0, mem_req_o, io_req_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int op = 0; op < 4; op++)
      for (int dec = 0; dec < 2; dec++)
        for (int rep = 0; rep < 2; rep++)
          for (int k = 0; k < 2; k++) begin
            sd = 8'(op * 37 + dec * 11 + rep * 5 + k);
            s  = 16'h4080 + 16'(op * 16);
            c  = (op >= 2) ? {8'(k ? 3 : 1), 8'h37} : 16'(k ? 3 : 1);
            a  = fill_fn(dec ? s[7:0] - 8'd2 : s[7:0] + 8'd2, sd);
            run(2'(op), 1'(dec), 1'(rep), s, 16'h40C0, c, a, 8'h29 ^ {2'(op), 1'(dec), 1'(rep), 4'h0}, sd);
          end

    // R2: zero count stands for 65536, pointers wrap
    run(2'd0, 1'b1, 1'b0, 16'h0000, 16'h0100, 16'h0000, 8'h00, 8'hFF, 8'h3C);
    // R1 R3: overlapping forward copy
    run(2'd0, 1'b0, 1'b1, 16'h2010, 16'h2012, 16'd6, 8'h00, 8'h00, 8'h51);
    // R6: early match mid-run
    run(2'd1, 1'b0, 1'b1, 16'h3020, 16'h0000, 16'd5, fill_fn(8'h21, 8'h77), 8'h81, 8'h77);
    run(2'd1, 1'b1, 1'b1, 16'h3020, 16'h0000, 16'd5, fill_fn(8'h1F, 8'h19), 8'h00, 8'h19);
    // R6: miss, zero flag left clear
    run(2'd1, 1'b0, 1'b1, 16'h3040, 16'h0000, 16'd4, fill_fn(8'hA0, 8'h08), 8'hFF, 8'h08);
    // R8: upper count byte zero means 256 transfers
    run(2'd3, 1'b0, 1'b1, 16'h5000, 16'h0000, 16'h00C3, 8'h00, 8'h00, 8'h6E);
    // R7: repeating port-in, downward
    run(2'd2, 1'b1, 1'b1, 16'h6003, 16'h1234, 16'h04F1, 8'h00, 8'hFF, 8'h90);

    chk(excl_bad == 0, "R9 exclusive buses", 32'(excl_bad), 32'd0);
    chk(hold_bad == 0, "R9 request hold", 32'(hold_bad), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule